// File: doc/BRIEF.md
# Cascaded Lookahead Binary Counter

This block is a wide synchronous up-counter assembled from identical 4-bit slices. Each slice has two count enables: a parallel enable and a trickle enable. It also has a synchronous clear, a synchronous parallel load and a carry output. A slice advances on a clock edge only when both of its enables are high. Its carry output is high when the slice holds hexadecimal F and its trickle enable is high. The parallel enable has no effect on the carry.

The slices are wired in a lookahead arrangement:

- The lowest slice takes both of its enables from the global count enable.
- The carry of the lowest slice drives the parallel enable of every higher slice.
- The second slice has its trickle enable tied high.
- Each slice above the second takes its trickle enable from the carry of the slice just below it.

With this wiring the higher slices step only on the single edge where the low slice rolls over from F to 0. The carry chain among the higher slices therefore has the full 16-cycle period of the low slice to settle. The count stays exact across every nibble boundary.

Clear takes precedence over load, and load takes precedence over counting. The number of slices is a parameter.

Top module: `casc_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0 and tc_o is 0.
- R2: On each clock edge with cnt_en_i high and clr_i and load_i low, count_o increases by one, modulo 2^(4*NUM_SLICES). The all-ones value wraps to 0.
- R3: On a clock edge with cnt_en_i, clr_i and load_i all low, count_o keeps its value.
- R4: On a clock edge with load_i high and clr_i low, count_o takes the value of load_data_i.
- R5: On a clock edge with clr_i high, count_o becomes 0, whatever load_i and cnt_en_i are.
- R6: When load_i and cnt_en_i are both high, the loaded value is not incremented on that edge.
- R7: tc_o is combinational. It is high exactly when count_o is all ones and cnt_en_i is high.
- R8: Suppose counting is enabled and the low nibble (bits 3:0) steps through E, F and 0 on successive edges. The bits above the low nibble stay unchanged on the E-to-F step. They increase by one on the F-to-0 step. They stay unchanged again on the following step.
- R9: A count whose low eight bits are EF, with all bits above them at F, reaches all zeros after 17 enabled steps. The same start with the top bit 0 reaches exactly the next power of two, never a lower value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear, highest priority |
| load_i | input | 1 | Synchronous parallel load |
| cnt_en_i | input | 1 | Global count enable |
| load_data_i | input | 4*NUM_SLICES | Parallel load value |
| count_o | output | 4*NUM_SLICES | Current count |
| tc_o | output | 1 | Terminal count: all ones while enabled |

## Verification
The bench builds the counter with NUM_SLICES = 3, which gives a 12-bit count. At that width a full sweep of all 4096 values, plus the wrap back to zero, fits easily in the run. Every carry boundary is therefore compared against a reference integer counter, including the boundary where two stacked higher slices both pass through their trickle-enable path. Three slices is the smallest depth at which the trickle chain among the higher slices is used at all, so the long-carry cases of R9 are reached at this width.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;
  localparam int unsigned SLICE_W = 4;
  typedef logic [SLICE_W-1:0] nib_t;
endpackage

// File: rtl/casc_cnt_slice.sv
module casc_cnt_slice
  import casc_cnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic load_i,
  input  logic en_p_i,
  input  logic en_t_i,
  input  nib_t d_i,
  output nib_t q_o,
  output logic carry_o
);
  nib_t q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q_q <= '0;
    else if (clr_i)             q_q <= '0;
    else if (load_i)            q_q <= d_i;
    else if (en_p_i && en_t_i)  q_q <= q_q + nib_t'(1);
  end

  // carry gated by trickle enable only
  assign carry_o = (&q_q) & en_t_i;
  assign q_o     = q_q;
endmodule

// File: rtl/casc_cnt_lookahead.sv
module casc_cnt_lookahead #(
  parameter int unsigned NUM_SLICES = 4
) (
  input  logic                  cnt_en_i,
  input  logic [NUM_SLICES-1:0] carry_i,
  output logic [NUM_SLICES-1:0] en_p_o,
  output logic [NUM_SLICES-1:0] en_t_o,
  output logic                  tc_o
);
  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_en
    if (k == 0) begin : g_low
      assign en_p_o[k] = cnt_en_i;
      assign en_t_o[k] = cnt_en_i;
    end else if (k == 1) begin : g_second
      assign en_p_o[k] = carry_i[0];
      assign en_t_o[k] = 1'b1;
    end else begin : g_upper
      assign en_p_o[k] = carry_i[0];
      assign en_t_o[k] = carry_i[k-1];
    end
  end

  if (NUM_SLICES == 1) begin : g_tc1
    assign tc_o = carry_i[0];
  end else begin : g_tcn
    assign tc_o = carry_i[NUM_SLICES-1] & carry_i[0];
  end
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_cnt_pkg::*;
#(
  parameter int unsigned NUM_SLICES = 4,
  localparam int unsigned W = NUM_SLICES * SLICE_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         cnt_en_i,
  input  logic [W-1:0] load_data_i,
  output logic [W-1:0] count_o,
  output logic         tc_o
);
  logic [NUM_SLICES-1:0] carry, en_p, en_t;

  casc_cnt_lookahead #(.NUM_SLICES(NUM_SLICES)) u_net (
    .cnt_en_i (cnt_en_i),
    .carry_i  (carry),
    .en_p_o   (en_p),
    .en_t_o   (en_t),
    .tc_o     (tc_o)
  );

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    casc_cnt_slice u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr_i),
      .load_i  (load_i),
      .en_p_i  (en_p[k]),
      .en_t_i  (en_t[k]),
      .d_i     (load_data_i[k*SLICE_W +: SLICE_W]),
      .q_o     (count_o[k*SLICE_W +: SLICE_W]),
      .carry_o (carry[k])
    );
  end
endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         load_i,
  input logic         cnt_en_i,
  input logic [W-1:0] load_data_i,
  input logic [W-1:0] count_o,
  input logic         tc_o
);
  localparam int unsigned UW = (W > 4) ? W - 4 : 1;

  // R1
  always_comb if (!rst_ni) reset_state_chk: assert (count_o == '0 && !tc_o);

  // R5
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> count_o == '0);

  // R4
  load_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && load_i) |=> count_o == $past(load_data_i));

  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && cnt_en_i) |=> count_o == W'($past(count_o) + 1'b1));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !load_i && !cnt_en_i) |=> $stable(count_o));

  // R7
  tc_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (&count_o && cnt_en_i));

  if (W > 4) begin : g_upper
    // R8
    upper_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !load_i && cnt_en_i && count_o[3:0] == 4'hF)
      |=> count_o[W-1:4] == UW'($past(count_o[W-1:4]) + 1'b1));
    // R8
    upper_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !load_i && count_o[3:0] != 4'hF) |=> $stable(count_o[W-1:4]));
  end
endmodule

bind casc_counter casc_counter_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .load_i      (load_i),
  .cnt_en_i    (cnt_en_i),
  .load_data_i (load_data_i),
  .count_o     (count_o),
  .tc_o        (tc_o)
);

// File: tb/casc_counter_test.sv
module casc_counter_test;
  localparam int NS = 3;
  localparam int W  = NS * 4;
  localparam int MOD = 1 << W;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0;
  logic         load_i = 1'b0;
  logic         cnt_en_i = 1'b0;
  logic [W-1:0] load_data_i = '0;
  logic [W-1:0] count_o;
  logic         tc_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  casc_counter #(.NUM_SLICES(NS)) uut (
    .clk_i, .rst_ni, .clr_i, .load_i, .cnt_en_i, .load_data_i, .count_o, .tc_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance one edge, return at the following falling edge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic set_in(input bit c, input bit l, input bit e, input int d);
    clr_i = c; load_i = l; cnt_en_i = e; load_data_i = W'(d);
    #1;
  endtask

  task automatic load_val(input int v);
    set_in(0, 1, 0, v);
    step();
    set_in(0, 0, 0, 0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 count", int'(count_o), 0);
    chk("R1 tc", int'(tc_o), 0);
    step();
    rst_ni = 1'b1;
    step();
    chk("R1 after release", int'(count_o), 0);
  endtask

  task automatic t_sweep();
    int ref_v = int'(count_o);
    set_in(0, 0, 1, 0);
    for (int i = 0; i < MOD + 2; i++) begin
      chk("R7 tc while enabled", int'(tc_o), (ref_v == MOD - 1) ? 1 : 0);
      step();
      ref_v = (ref_v + 1) % MOD;
      chk("R2 sweep", int'(count_o), ref_v);
    end
    set_in(0, 0, 0, 0);
  endtask

  task automatic t_hold();
    load_val('hFFF);
    chk("R4 load", int'(count_o), 'hFFF);
    chk("R7 tc low when disabled", int'(tc_o), 0);
    for (int i = 0; i < 5; i++) step();
    chk("R3 hold", int'(count_o), 'hFFF);
    load_val('h5A5);
    step();
    chk("R3 hold second value", int'(count_o), 'h5A5);
  endtask

  task automatic t_nibble_edges();
    load_val('h3AE);
    set_in(0, 0, 1, 0);
    step(); chk("R8 E to F", int'(count_o), 'h3AF);
    step(); chk("R8 F to 0", int'(count_o), 'h3B0);
    step(); chk("R8 0 to 1", int'(count_o), 'h3B1);
    set_in(0, 0, 0, 0);
  endtask

  task automatic t_long_carry();
    load_val('hFEF);
    set_in(0, 0, 1, 0);
    for (int i = 0; i < 16; i++) step();
    chk("R9 reaches all ones", int'(count_o), 'hFFF);
    step();
    chk("R9 wrap to zero", int'(count_o), 0);
    set_in(0, 0, 0, 0);
    load_val('h7EF);
    set_in(0, 0, 1, 0);
    for (int i = 0; i < 17; i++) step();
    chk("R9 next power of two", int'(count_o), 'h800);
    set_in(0, 0, 0, 0);
  endtask

  task automatic t_priority();
    load_val('h111);
    set_in(0, 1, 1, 'h2C4);
    step();
    chk("R6 load beats count", int'(count_o), 'h2C4);
    set_in(1, 1, 1, 'h777);
    step();
    chk("R5 clear beats load", int'(count_o), 0);
    set_in(0, 0, 0, 0);
    load_val('h0F0);
    set_in(1, 0, 0, 0);
    step();
    chk("R5 clear alone", int'(count_o), 0);
    set_in(0, 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_nibble_edges();
    t_long_carry();
    t_priority();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule